// File: doc/BRIEF.md
# I/O Interrupt Request Qualifier

This block sits beside an I/O channel and decides whether the events reported by the channel datapath turn into an interrupt request. Five control flags, held from the command doubleword that is currently executing, select which conditions the program wants to hear about. The datapath reports eleven kinds of event, each as a single-cycle pulse. Each event passes through its own gate to become a qualified condition:

- Some conditions need one flag set.
- Some need two flags set together.
- Incorrect length also needs the suppress flag clear.
- Processor halt and command-fetch parity errors ignore the flags.

Any qualified condition sets a sticky pending flag. It also sets the matching bit of a status vector. The acknowledge logic reads the pending flag and the status vector together, then clears both with an acknowledge pulse. If a new qualified event arrives in the same cycle as the acknowledge, the new event is kept. All outputs are registered, so a qualified event shows one clock edge after its pulse.

Top module: `io_irq_qualifier`

## Requirements
- R1: A count-zero pulse sets status bit 0 only when the zero-count flag is 1. Otherwise it changes nothing.
- R2: A channel-end pulse sets status bit 1 only when the channel-end flag is 1.
- R3: A transmission memory error sets bit 2, and a transmission data error sets bit 3. Each does so only when the unusual-end flag and the halt-on-transmission-error flag are both 1.
- R4: An incorrect-length pulse sets bit 4 only when three things hold: the unusual-end flag is 1, the halt-on-transmission-error flag is 1, and the suppress-length flag is 0.
- R5: With the unusual-end flag at 1, four errors set their own bits: memory address error sets bit 5, processor memory error bit 6, processor control error bit 7, and device address parity error bit 8. With that flag at 0, these four errors change nothing.
- R6: A processor halt sets bit 9, and a command-fetch parity error sets bit 10, whatever the flags are.
- R7: At the clock edge that samples any qualified condition, the pending flag goes to 1. Every condition qualified in that cycle sets its own status bit.
- R8: The pending flag and the status bits stay set until an acknowledge. New conditions are OR-ed into the status vector.
- R9: An acknowledge in a cycle with no qualified condition clears the pending flag and all status bits at the next edge.
- R10: When an acknowledge and a qualified condition share a cycle, the pending flag stays 1. The status vector then holds only the bits of the conditions from that cycle.
- R11: While reset is asserted, the pending flag and the status vector are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flg_zero_cnt | input | 1 | Interrupt on count reaching zero |
| flg_chan_end | input | 1 | Interrupt on channel end |
| flg_unusual | input | 1 | Interrupt on unusual end |
| flg_halt_xmit | input | 1 | Halt on transmission error |
| flg_suppress_len | input | 1 | Suppress incorrect-length reporting |
| ev_count_zero | input | 1 | Byte count reached zero |
| ev_chan_end | input | 1 | Channel end |
| ev_xmit_mem_err | input | 1 | Transmission memory error |
| ev_xmit_data_err | input | 1 | Transmission data error |
| ev_bad_length | input | 1 | Incorrect length |
| ev_mem_addr_err | input | 1 | Memory address error |
| ev_proc_mem_err | input | 1 | Processor memory error |
| ev_proc_ctl_err | input | 1 | Processor control error |
| ev_dev_addr_par | input | 1 | Device connection address parity error |
| ev_proc_halt | input | 1 | Processor halt |
| ev_cmd_parity | input | 1 | Parity error reading a command doubleword |
| ack | input | 1 | Acknowledge addressed to this channel |
| irq_pending | output | 1 | Sticky interrupt request |
| irq_status | output | 11 | Sticky record of the qualified conditions |

## Verification
The hardest case to reach is an acknowledge that lands in the same cycle as a new qualified event. It is only visible when status bits left over from earlier events differ from the bits of the new event. The stimulus first builds up a pending state from a halt and a parity error. It then drives the acknowledge together with a fresh parity error, and expects the status to drop to that single bit while the pending flag stays up. The incorrect-length gate is a second hard case. Reaching it needs three flags in a specific pattern, so the stimulus walks it with suppress set, then with halt-on-error clear, then with both allowing the event.

// File: rtl/io_irq_qualifier.sv
module io_irq_qualifier (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flg_zero_cnt,
  input  logic        flg_chan_end,
  input  logic        flg_unusual,
  input  logic        flg_halt_xmit,
  input  logic        flg_suppress_len,
  input  logic        ev_count_zero,
  input  logic        ev_chan_end,
  input  logic        ev_xmit_mem_err,
  input  logic        ev_xmit_data_err,
  input  logic        ev_bad_length,
  input  logic        ev_mem_addr_err,
  input  logic        ev_proc_mem_err,
  input  logic        ev_proc_ctl_err,
  input  logic        ev_dev_addr_par,
  input  logic        ev_proc_halt,
  input  logic        ev_cmd_parity,
  input  logic        ack,
  output logic        irq_pending,
  output logic [10:0] irq_status
);
  localparam int NCOND = 11;

  logic             xmit_ok;
  logic [NCOND-1:0] qual;
  logic             any_qual;

  assign xmit_ok  = flg_unusual & flg_halt_xmit;

  assign qual[0]  = ev_count_zero    & flg_zero_cnt;
  assign qual[1]  = ev_chan_end      & flg_chan_end;
  assign qual[2]  = ev_xmit_mem_err  & xmit_ok;
  assign qual[3]  = ev_xmit_data_err & xmit_ok;
  assign qual[4]  = ev_bad_length    & xmit_ok & ~flg_suppress_len;
  assign qual[5]  = ev_mem_addr_err  & flg_unusual;
  assign qual[6]  = ev_proc_mem_err  & flg_unusual;
  assign qual[7]  = ev_proc_ctl_err  & flg_unusual;
  assign qual[8]  = ev_dev_addr_par  & flg_unusual;
  assign qual[9]  = ev_proc_halt;
  assign qual[10] = ev_cmd_parity;

  assign any_qual = |qual;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_pending <= 1'b0;
      irq_status  <= '0;
    end else if (ack) begin
      irq_pending <= any_qual;
      irq_status  <= qual;
    end else begin
      irq_pending <= irq_pending | any_qual;
      irq_status  <= irq_status | qual;
    end
  end
endmodule

module io_irq_qualifier_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        flg_zero_cnt,
  input logic        flg_chan_end,
  input logic        flg_unusual,
  input logic        flg_halt_xmit,
  input logic        flg_suppress_len,
  input logic        ev_count_zero,
  input logic        ev_chan_end,
  input logic        ev_xmit_mem_err,
  input logic        ev_xmit_data_err,
  input logic        ev_bad_length,
  input logic        ev_mem_addr_err,
  input logic        ev_proc_mem_err,
  input logic        ev_proc_ctl_err,
  input logic        ev_dev_addr_par,
  input logic        ev_proc_halt,
  input logic        ev_cmd_parity,
  input logic        ack,
  input logic        irq_pending,
  input logic [10:0] irq_status
);
  logic any_ev;
  assign any_ev = ev_count_zero | ev_chan_end | ev_xmit_mem_err | ev_xmit_data_err |
                  ev_bad_length | ev_mem_addr_err | ev_proc_mem_err | ev_proc_ctl_err |
                  ev_dev_addr_par | ev_proc_halt | ev_cmd_parity;

  assert_count_zero_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_status[0]) |-> $past(ev_count_zero && flg_zero_cnt));

  assert_chan_end_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_status[1]) |-> $past(ev_chan_end && flg_chan_end));

  assert_xmit_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_status[2]) |-> $past(ev_xmit_mem_err && flg_unusual && flg_halt_xmit));

  assert_length_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_status[4]) |-> $past(ev_bad_length && flg_unusual && flg_halt_xmit && !flg_suppress_len));

  assert_addr_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_status[5]) |-> $past(ev_mem_addr_err && flg_unusual));

  assert_halt_always_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_proc_halt |=> (irq_pending && irq_status[9]));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending && !ack) |=> irq_pending);

  assert_ack_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !any_ev) |=> (!irq_pending && irq_status == '0));

  assert_ack_race_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ev_cmd_parity) |=> irq_pending);
endmodule

bind io_irq_qualifier io_irq_qualifier_chk u_chk (.*);

// File: tb/io_irq_qualifier_bench.sv
module io_irq_qualifier_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0]  flg = '0;
  logic [10:0] ev = '0;
  logic ack = 1'b0;
  logic irq_pending;
  logic [10:0] irq_status;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic        q_pend[$];
  logic [10:0] q_stat[$];
  string       q_tag[$];

  logic        m_pend = 1'b0;
  logic [10:0] m_stat = '0;

  always #10 clk = ~clk;

  io_irq_qualifier u_io_irq_qualifier (
    .clk(clk), .rst_n(rst_n),
    .flg_zero_cnt(flg[0]), .flg_chan_end(flg[1]), .flg_unusual(flg[2]),
    .flg_halt_xmit(flg[3]), .flg_suppress_len(flg[4]),
    .ev_count_zero(ev[0]), .ev_chan_end(ev[1]), .ev_xmit_mem_err(ev[2]),
    .ev_xmit_data_err(ev[3]), .ev_bad_length(ev[4]), .ev_mem_addr_err(ev[5]),
    .ev_proc_mem_err(ev[6]), .ev_proc_ctl_err(ev[7]), .ev_dev_addr_par(ev[8]),
    .ev_proc_halt(ev[9]), .ev_cmd_parity(ev[10]), .ack(ack),
    .irq_pending(irq_pending), .irq_status(irq_status)
  );

  function automatic logic [10:0] gate(input logic [4:0] f, input logic [10:0] e);
    logic [10:0] g;
    g[0]  = e[0] & f[0];
    g[1]  = e[1] & f[1];
    g[2]  = e[2] & f[2] & f[3];
    g[3]  = e[3] & f[2] & f[3];
    g[4]  = e[4] & f[2] & f[3] & ~f[4];
    for (int i = 5; i <= 8; i++) g[i] = e[i] & f[2];
    g[9]  = e[9];
    g[10] = e[10];
    return g;
  endfunction

  task automatic step(input logic [4:0] f, input logic [10:0] e, input logic a, input string tag);
    logic [10:0] g;
    @(negedge clk);
    flg = f; ev = e; ack = a;
    g = gate(f, e);
    if (a) begin m_pend = |g; m_stat = g; end
    else begin m_pend = m_pend | (|g); m_stat = m_stat | g; end
    @(posedge clk);
    #1;
    q_pend.push_back(m_pend);
    q_stat.push_back(m_stat);
    q_tag.push_back(tag);
    ev = '0; ack = 1'b0;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (q_pend.size() > 0) begin
        logic ep;
        logic [10:0] es;
        string t;
        ep = q_pend.pop_front();
        es = q_stat.pop_front();
        t  = q_tag.pop_front();
        checks++;
        if (irq_pending !== ep || irq_status !== es) begin
          errors++;
          $display("FAIL %s: pending=%0b status=%03h expected pending=%0b status=%03h",
                   t, irq_pending, irq_status, ep, es);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #5;
    checks++;
    if (irq_pending !== 1'b0 || irq_status !== '0) begin
      errors++;
      $display("FAIL R11: pending=%0b status=%03h expected pending=0 status=000", irq_pending, irq_status);
    end
    @(negedge clk);
    rst_n = 1'b1;

    step(5'b00000, 11'h001, 1'b0, "R1 count-zero flag clear");
    step(5'b00001, 11'h001, 1'b0, "R1 count-zero flag set");
    step(5'b00000, 11'h000, 1'b1, "R9 ack clears");
    step(5'b11101, 11'h002, 1'b0, "R2 chan-end flag clear");
    step(5'b00010, 11'h002, 1'b0, "R2 chan-end flag set");
    step(5'b00000, 11'h000, 1'b1, "R9 ack clears");
    step(5'b00100, 11'h00C, 1'b0, "R3 xmit errors halt flag clear");
    step(5'b01000, 11'h00C, 1'b0, "R3 xmit errors unusual clear");
    step(5'b01100, 11'h004, 1'b0, "R3 xmit mem error qualified");
    step(5'b01100, 11'h008, 1'b0, "R8 xmit data error accumulates");
    step(5'b00000, 11'h000, 1'b0, "R8 idle holds");
    step(5'b00000, 11'h000, 1'b1, "R9 ack clears");
    step(5'b11100, 11'h010, 1'b0, "R4 length suppressed");
    step(5'b00100, 11'h010, 1'b0, "R4 length halt clear");
    step(5'b01100, 11'h010, 1'b0, "R4 length qualified");
    step(5'b00000, 11'h000, 1'b1, "R9 ack clears");
    step(5'b11011, 11'h1E0, 1'b0, "R5 address errors unusual clear");
    step(5'b00100, 11'h1E0, 1'b0, "R5 R7 four address errors");
    step(5'b00000, 11'h000, 1'b1, "R9 ack clears");
    step(5'b00000, 11'h200, 1'b0, "R6 halt without flags");
    step(5'b00000, 11'h400, 1'b0, "R6 command parity without flags");
    step(5'b00000, 11'h000, 1'b0, "R8 idle holds");
    step(5'b00000, 11'h400, 1'b1, "R10 ack with new parity event");
    step(5'b00000, 11'h000, 1'b1, "R9 ack clears");
    step(5'b01111, 11'h7FF, 1'b0, "R7 all conditions at once");
    step(5'b00000, 11'h000, 1'b1, "R9 ack clears");
    step(5'b11111, 11'h7FF, 1'b0, "R7 all events length suppressed");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule